// File: doc/BRIEF.md
# Depth-Cascaded Banked Memory

This block builds one deep memory out of several identical two-port RAM banks. Every bank receives the same lower write address, write data and lower read address. The word space is split among the banks by the upper address bits. On the write side those upper bits are decoded into one enable per bank, so a write reaches a single bank. On the read side every bank produces a registered word, and a multiplexer picks one of them. The multiplexer select is taken from the upper read-address bits, registered under the same read enable as the bank outputs, so that select and data always come from the same read.

With the default parameters there are four banks of 512 words by 4 bits, which gives a 2048 x 4 memory. Write address bits [10:9] choose the bank to write and read address bits [10:9] choose the bank to read. Writes are synchronous to the write clock and use the write enable as a clock enable. Reads are synchronous to the read clock and use the read enable as a clock enable. The two clocks are independent. The read side has an asynchronous active-low reset, which clears the output registers and the registered select. The RAM contents are never reset.

Top module: `casc_mem`

## Requirements
- R1: When `we` is high at a rising `wclk` edge, `wd` is stored only at word `wa[8:0]` of bank `wa[10:9]`. A later read of address `wa` returns `wd`.
- R2: When `we` is low at a rising `wclk` edge, no bank is written, whatever the values of `wa` and `wd`.
- R3: When `re` is high at a rising `rclk` edge, `rd` shows the word stored at `ra` after that edge. The read latency is one cycle.
- R4: When `re` is low at a rising `rclk` edge, `rd` keeps its previous value.
- R5: The bank select is sampled under `re` together with the bank data. If `ra[10:9]` changes while `re` is low, `rd` still shows the word from the last read.
- R6: While `rst_n` is low, and after it is released until the first read, `rd` is 0.
- R7: Addresses that share `ra[8:0]` but differ in bits [10:9] are separate words. A write to one of them leaves the others unchanged.
- R8: If a write and a read target the same address on the same rising edge of a shared clock, the read returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-side registers |
| we | input | 1 | Write enable; acts as a clock enable on `wclk` |
| wa | input | 11 | Write word address; bits [10:9] select the bank |
| wd | input | 4 | Write data |
| re | input | 1 | Read enable; acts as a clock enable on `rclk` |
| ra | input | 11 | Read word address; bits [10:9] select the bank |
| rd | output | 4 | Registered read data |

## Verification
The hardest case to reach from the ports is a mismatch between the registered select and the registered bank data. It only shows up when the read address moves to another bank while `re` is low. The stimulus therefore reads a word in bank 0, then holds `re` low and moves `ra` into bank 3, and expects the bank-0 word to stay on the output. Aliasing between banks is made visible by writing the same low address in every bank with a pattern that depends on the bank. The bench then rewrites only one of those banks and reads back all four.

// File: rtl/casc_mem_pkg.sv
package casc_mem_pkg;
    parameter int unsigned DEF_DATA_W  = 4;
    parameter int unsigned DEF_BANK_AW = 9;
    parameter int unsigned DEF_BANKS   = 4;
endpackage

// File: rtl/casc_bank_ram.sv
module casc_bank_ram #(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned BANK_AW = 9
) (
    input  logic               wclk,
    input  logic               rclk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [BANK_AW-1:0] wa,
    input  logic [DATA_W-1:0]  wd,
    input  logic               re,
    input  logic [BANK_AW-1:0] ra,
    output logic [DATA_W-1:0]  q
);
    localparam int unsigned DEPTH = 1 << BANK_AW;

    logic [DATA_W-1:0] store [DEPTH];

    // Synchronous write, enable used as clock enable
    always_ff @(posedge wclk) begin
        if (we) begin
            store[wa] <= wd;
        end
    end

    // Synchronous read, enable used as clock enable
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= store[ra];
        end
    end
endmodule

// File: rtl/casc_wr_decode.sv
module casc_wr_decode #(
    parameter int unsigned BANKS = 4
) (
    input  logic                     we,
    input  logic [$clog2(BANKS)-1:0] bank_idx,
    output logic [BANKS-1:0]         bank_we
);
    for (genvar g = 0; g < BANKS; g++) begin : g_dec
        assign bank_we[g] = we && (bank_idx == g[$clog2(BANKS)-1:0]);
    end
endmodule

// File: rtl/casc_rd_select.sv
module casc_rd_select #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned BANKS  = 4
) (
    input  logic                           rclk,
    input  logic                           rst_n,
    input  logic                           re,
    input  logic [$clog2(BANKS)-1:0]       bank_idx,
    input  logic [BANKS-1:0][DATA_W-1:0]   bank_q,
    output logic [$clog2(BANKS)-1:0]       sel_q,
    output logic [DATA_W-1:0]              rd
);
    // Select is delayed by the same register stage as the bank data
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (re) begin
            sel_q <= bank_idx;
        end
    end

    always_comb begin
        rd = bank_q[sel_q];
    end
endmodule

// File: rtl/casc_mem.sv
module casc_mem
    import casc_mem_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned BANK_AW = DEF_BANK_AW,
    parameter int unsigned BANKS   = DEF_BANKS
) (
    input  logic                                 wclk,
    input  logic                                 rclk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [BANK_AW+$clog2(BANKS)-1:0]     wa,
    input  logic [DATA_W-1:0]                    wd,
    input  logic                                 re,
    input  logic [BANK_AW+$clog2(BANKS)-1:0]     ra,
    output logic [DATA_W-1:0]                    rd
);
    localparam int unsigned SEL_W  = $clog2(BANKS);
    localparam int unsigned ADDR_W = BANK_AW + SEL_W;

    logic [BANKS-1:0]             bank_we;
    logic [BANKS-1:0][DATA_W-1:0] bank_q;
    logic [SEL_W-1:0]             sel_q;

    casc_wr_decode #(.BANKS(BANKS)) u_dec (
        .we       (we),
        .bank_idx (wa[ADDR_W-1:BANK_AW]),
        .bank_we  (bank_we)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        casc_bank_ram #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) u_ram (
            .wclk  (wclk),
            .rclk  (rclk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .wa    (wa[BANK_AW-1:0]),
            .wd    (wd),
            .re    (re),
            .ra    (ra[BANK_AW-1:0]),
            .q     (bank_q[b])
        );
    end

    casc_rd_select #(.DATA_W(DATA_W), .BANKS(BANKS)) u_sel (
        .rclk     (rclk),
        .rst_n    (rst_n),
        .re       (re),
        .bank_idx (ra[ADDR_W-1:BANK_AW]),
        .bank_q   (bank_q),
        .sel_q    (sel_q),
        .rd       (rd)
    );
endmodule

// File: rtl/casc_mem_chk.sv
module casc_mem_chk #(
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned BANK_AW = 9,
    parameter int unsigned BANKS   = 4
) (
    input logic                              wclk,
    input logic                              rclk,
    input logic                              rst_n,
    input logic                              we,
    input logic [BANK_AW+$clog2(BANKS)-1:0]  wa,
    input logic                              re,
    input logic [BANK_AW+$clog2(BANKS)-1:0]  ra,
    input logic [DATA_W-1:0]                 rd,
    input logic [BANKS-1:0]                  bank_we,
    input logic [$clog2(BANKS)-1:0]          sel_q
);
    localparam int unsigned ADDR_W = BANK_AW + $clog2(BANKS);

    a_r1_single_bank: assert property (@(posedge wclk) disable iff (!rst_n)
        we |-> $onehot(bank_we));

    a_r1_addressed_bank: assert property (@(posedge wclk) disable iff (!rst_n)
        we |-> bank_we[wa[ADDR_W-1:BANK_AW]]);

    a_r2_no_write_idle: assert property (@(posedge wclk) disable iff (!rst_n)
        !we |-> (bank_we == '0));

    a_r4_hold_output: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rd));

    a_r5_select_aligned: assert property (@(posedge rclk) disable iff (!rst_n)
        re |=> (sel_q == $past(ra[ADDR_W-1:BANK_AW])));

    a_r5_select_held: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(sel_q));
endmodule

bind casc_mem casc_mem_chk #(
    .DATA_W  (DATA_W),
    .BANK_AW (BANK_AW),
    .BANKS   (BANKS)
) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst_n   (rst_n),
    .we      (we),
    .wa      (wa),
    .re      (re),
    .ra      (ra),
    .rd      (rd),
    .bank_we (bank_we),
    .sel_q   (sel_q)
);

// File: tb/casc_mem_tb_top.sv
`timescale 1ns/1ps
module casc_mem_tb_top;
    localparam int AW = 11;
    localparam int DW = 4;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        string         req;
        int            due;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [AW-1:0] ra = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] model [2048];
    logic [DW-1:0] last_val = '0;
    sb_item_t sb [$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    casc_mem dut_i (
        .wclk (clk), .rclk (clk), .rst_n (rst_n),
        .we (we), .wa (wa), .wd (wd),
        .re (re), .ra (ra), .rd (rd)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[3:0] ^ {a[10:9], a[10:9]};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp, input logic [AW-1:0] a);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, a, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic en);
        @(negedge clk);
        re = 1'b0; we = en; wa = a; wd = d;
        if (en) model[a] = d;
    endtask

    task automatic rd_req(input logic [AW-1:0] a, input string req);
        sb_item_t it;
        @(negedge clk);
        we = 1'b0; re = 1'b1; ra = a;
        it.addr = a; it.exp = model[a]; it.req = req; it.due = cyc + 1;
        last_val = model[a];
        sb.push_back(it);
    endtask

    task automatic hold(input logic [AW-1:0] a, input string req);
        sb_item_t it;
        @(negedge clk);
        we = 1'b0; re = 1'b0; ra = a;
        it.addr = a; it.exp = last_val; it.req = req; it.due = cyc + 1;
        sb.push_back(it);
    endtask

    task automatic wr_rd(input logic [AW-1:0] a, input logic [DW-1:0] d);
        sb_item_t it;
        @(negedge clk);
        we = 1'b1; re = 1'b1; wa = a; ra = a; wd = d;
        it.addr = a; it.exp = model[a]; it.req = "R8"; it.due = cyc + 1;
        last_val = model[a];
        sb.push_back(it);
        model[a] = d;
    endtask

    task automatic idle();
        @(negedge clk);
        we = 1'b0; re = 1'b0;
    endtask

    // Monitor: compare each queued expectation once its cycle has come
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                sb_item_t it;
                it = sb.pop_front();
                check(it.req, rd, it.exp, it.addr);
            end
        end
    end

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6", rd, '0, '0);           // output cleared in reset
        rst_n = 1'b1;

        // R1: fill every bank with a bank-dependent pattern
        for (int a = 0; a < 2048; a++) wr(a[AW-1:0], pat(a[AW-1:0]), 1'b1);
        idle();
        @(negedge clk);
        check("R6", rd, '0, '0);           // no read yet, still zero

        // R1/R3/R7: read everything back
        for (int a = 0; a < 2048; a++) rd_req(a[AW-1:0], "R3");

        // R2: write with we low must not change anything
        wr(11'h005, 4'hE, 1'b0);
        wr(11'h605, 4'hE, 1'b0);
        rd_req(11'h005, "R2");
        rd_req(11'h605, "R2");

        // R7: rewrite only bank 3 at low address 0x2A, others untouched
        wr(11'h62A, 4'h9, 1'b1);
        rd_req(11'h02A, "R7");
        rd_req(11'h22A, "R7");
        rd_req(11'h42A, "R7");
        rd_req(11'h62A, "R1");

        // R4/R5: read bank 0, then move address to bank 3 with re low
        rd_req(11'h010, "R5");
        hold(11'h610, "R5");
        hold(11'h410, "R4");
        hold(11'h210, "R4");
        rd_req(11'h610, "R3");
        hold(11'h010, "R5");

        // R8: same-edge write and read of one address returns old word
        wr_rd(11'h3C3, 4'h1);
        rd_req(11'h3C3, "R1");
        wr_rd(11'h7FF, 4'h0);
        rd_req(11'h7FF, "R1");

        repeat (4) idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule